// File: doc/BRIEF.md
# LCD Nibble Transfer Sequencer

This block drives a character LCD controller that runs with a 4-bit data path, reached through an 8-bit port expander. A request carries a byte, a flag that selects the character-data register or the command register, and a mode bit. The block breaks the request into a fixed series of expander frames. It offers each frame to a downstream serial write engine through a valid/ready handshake.

Each LCD nibble becomes three frames. The first frame places register select with the data lines cleared. The second frame presents the nibble with the enable strobe high. The third frame keeps the nibble and drops the strobe. A full byte sends its upper nibble first, then its lower nibble. Single-nibble mode, which power-up initialisation needs, sends only the phase for bits 7..4.

After each frame the block waits for the engine's write-complete pulse, then for a programmable settle interval, before it offers the next frame. A one-cycle completion pulse marks the end of the request.

Top module: `lcd_nibble_seq`

## Requirements
- R1: In every offered frame, bit 1 (read/write) and bit 3 are 0. Bit 0 is register select, bit 2 is enable, and bits 7..4 carry LCD lines D7..D4.
- R2: Bit 0 of every frame of a request equals the `req_is_data` value captured at acceptance: 1 for character data, 0 for a command.
- R3: A nibble N is sent as three frames in this order: setup (bits 7..4 = 0, enable 0), strobe (bits 7..4 = N, enable 1), release (bits 7..4 = N, enable 0).
- R4: With `req_single` = 0, six frames are sent: the three frames for bits 7..4 of the byte, then the three frames for bits 3..0.
- R5: With `req_single` = 1, only the three frames for bits 7..4 are sent, and bits 3..0 have no effect.
- R6: While `frm_valid` is high and `frm_ready` is low, `frm_valid` stays high and `frm_data` holds its value.
- R7: After a frame's handshake, the block waits for `wr_done`. Let S be the `settle_cycles` value captured at acceptance. The next frame is offered S+1 cycles after the cycle in which `wr_done` is high, and never in the cycle right after it.
- R8: `seq_done` is high for exactly one cycle per request. It is raised S+1 cycles after the `wr_done` of the last frame.
- R9: `req_ready` is low from acceptance until the request ends. A `req_valid` during that time is ignored and produces no frames.
- R10: After reset, `req_ready` is 1 and both `frm_valid` and `seq_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_byte | input | 8 | Byte (or upper nibble in single mode) |
| req_is_data | input | 1 | 1 = character data, 0 = command |
| req_single | input | 1 | 1 = send bits 7..4 only |
| settle_cycles | input | SETTLE_W | Settle length captured at acceptance |
| frm_valid | output | 1 | Expander frame offered |
| frm_ready | input | 1 | Write engine takes the frame |
| frm_data | output | 8 | Expander frame |
| wr_done | input | 1 | Write engine finished the last frame |
| seq_done | output | 1 | One-cycle end-of-request pulse |

## Verification
The properties assume that the write engine raises `wr_done` only after it has taken a frame, and only once per frame. They also assume that it never pulses `wr_done` while a frame is still being offered. The bench's engine model follows this rule. It raises `frm_ready` for a single cycle, waits a random number of cycles, and then gives exactly one `wr_done` pulse. Requests that arrive while the block is busy are driven only on the request side, so the frame-side rules hold.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    localparam int FRAME_W = 8;
    localparam int NIB_W   = FRAME_W / 2;
    localparam int RS_POS  = 0;
    localparam int EN_POS  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OFFER,
        ST_WAIT,
        ST_SETTLE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_STROBE,
        PH_RELEASE
    } nib_phase_e;
endpackage

// File: rtl/lcd_frame_pack.sv
module lcd_frame_pack
    import lcd_seq_pkg::*;
(
    input  nib_phase_e         phase,
    input  logic [NIB_W-1:0]   nibble,
    input  logic               rs,
    output logic [FRAME_W-1:0] frame
);
    always_comb begin
        frame         = '0;
        frame[RS_POS] = rs;
        frame[EN_POS] = (phase == PH_STROBE);
        if (phase != PH_SETUP) begin
            frame[FRAME_W-1:NIB_W] = nibble;
        end
    end
endmodule

// File: rtl/lcd_settle_timer.sv
module lcd_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_nibble_seq.sv
module lcd_nibble_seq
    import lcd_seq_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [FRAME_W-1:0]  req_byte,
    input  logic                req_is_data,
    input  logic                req_single,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                frm_valid,
    input  logic                frm_ready,
    output logic [FRAME_W-1:0]  frm_data,
    input  logic                wr_done,
    output logic                seq_done
);
    typedef struct packed {
        seq_state_e          state;
        nib_phase_e          phase;
        logic                lo_half;
        logic                single;
        logic                rs;
        logic [FRAME_W-1:0]  byte_v;
        logic [SETTLE_W-1:0] settle;
        logic                done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic              tmr_load;
    logic              tmr_expired;
    logic              last_frame;
    logic [NIB_W-1:0]  cur_nib;

    assign cur_nib    = r_q.lo_half ? r_q.byte_v[NIB_W-1:0] : r_q.byte_v[FRAME_W-1:NIB_W];
    assign last_frame = (r_q.phase == PH_RELEASE) && (r_q.single || r_q.lo_half);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state   = ST_OFFER;
                    r_d.phase   = PH_SETUP;
                    r_d.lo_half = 1'b0;
                    r_d.single  = req_single;
                    r_d.rs      = req_is_data;
                    r_d.byte_v  = req_byte;
                    r_d.settle  = settle_cycles;
                end
            end
            ST_OFFER: begin
                if (frm_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (wr_done) begin
                    r_d.state = ST_SETTLE;
                    tmr_load  = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    if (last_frame) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_OFFER;
                        if (r_q.phase == PH_RELEASE) begin
                            r_d.phase   = PH_SETUP;
                            r_d.lo_half = 1'b1;
                        end else if (r_q.phase == PH_SETUP) begin
                            r_d.phase = PH_STROBE;
                        end else begin
                            r_d.phase = PH_RELEASE;
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, phase: PH_SETUP, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    lcd_settle_timer #(.W(SETTLE_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (r_q.settle),
        .expired  (tmr_expired)
    );

    lcd_frame_pack i_pack (
        .phase  (r_q.phase),
        .nibble (cur_nib),
        .rs     (r_q.rs),
        .frame  (frm_data)
    );

    assign req_ready = (r_q.state == ST_IDLE);
    assign frm_valid = (r_q.state == ST_OFFER);
    assign seq_done  = r_q.done;
endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk
    import lcd_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               frm_valid,
    input logic               frm_ready,
    input logic [FRAME_W-1:0] frm_data,
    input logic               wr_done,
    input logic               seq_done
);
    // R1
    pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (frm_data[1] == 1'b0 && frm_data[3] == 1'b0));

    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data)));

    // R7
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !frm_valid);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R9
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> !req_ready);
endmodule

bind lcd_nibble_seq lcd_seq_chk i_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .frm_data  (frm_data),
    .wr_done   (wr_done),
    .seq_done  (seq_done)
);

// File: tb/test_lcd_nibble_seq.sv
module test_lcd_nibble_seq;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       req_valid = 0;
    logic       req_ready;
    logic [7:0] req_byte = 0;
    logic       req_is_data = 0;
    logic       req_single = 0;
    logic [7:0] settle_cycles = 0;
    logic       frm_valid;
    logic       frm_ready = 0;
    logic [7:0] frm_data;
    logic       wr_done = 0;
    logic       seq_done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] frame;
        bit         last;
        int         settle;
        string      tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    lcd_nibble_seq i_lcd_nibble_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_byte(req_byte), .req_is_data(req_is_data), .req_single(req_single),
        .settle_cycles(settle_cycles), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_data(frm_data), .wr_done(wr_done), .seq_done(seq_done)
    );

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_nibble(logic [3:0] n, bit rs, int st, bit last, string tag);
        exp_q.push_back('{{4'h0, 3'b000, rs}, 1'b0, st, tag});
        exp_q.push_back('{{n, 4'b0100} | {7'b0, rs}, 1'b0, st, tag});
        exp_q.push_back('{{n, 4'b0000} | {7'b0, rs}, last, st, tag});
    endtask

    task automatic send(logic [7:0] b, bit d, bit s, int st, bit poke, string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        push_nibble(b[7:4], d, st, s, tag);
        if (!s) push_nibble(b[3:0], d, st, 1'b1, tag);
        req_byte = b; req_is_data = d; req_single = s; settle_cycles = st[7:0];
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                req_valid = 1; req_byte = ~b; req_single = 0; req_is_data = ~d;
                // R9: busy request must be refused
                check(req_ready == 0, "R9", req_ready, 0);
                @(negedge clk);
            end
            req_valid = 0;
        end
    endtask

    // write-engine model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (frm_valid) begin
                logic [7:0] cap;
                exp_item_t it;
                int wt;
                int gap;
                bit have;
                cap = frm_data;
                wt = $urandom_range(0, 3);
                for (int i = 0; i < wt; i++) begin
                    @(negedge clk);
                    // R6: held while not accepted
                    check(frm_valid && frm_data == cap, "R6", frm_data, cap);
                end
                frm_ready = 1;
                @(negedge clk);
                frm_ready = 0;
                // R1: pad bits
                check(cap[1] == 0 && cap[3] == 0, "R1", cap, cap & 8'hF5);
                have = exp_q.size() != 0;
                if (!have) begin
                    // R9: no frames from ignored requests
                    check(0, "R9", cap, 0);
                    it = '{8'h00, 1'b0, 0, "R9"};
                end else begin
                    it = exp_q.pop_front();
                    // R2: register select
                    check(cap[0] == it.frame[0], "R2", cap[0], it.frame[0]);
                    check(cap == it.frame, it.tag, cap, it.frame);
                end
                wt = $urandom_range(0, 4);
                repeat (wt) @(negedge clk);
                wr_done = 1;
                @(negedge clk);
                wr_done = 0;
                gap = 0;
                while (!frm_valid && !seq_done && gap < 1000) begin
                    @(negedge clk);
                    gap++;
                end
                if (have) begin
                    // R7 / R8: settle timing
                    check(gap == it.settle + 1, it.last ? "R8" : "R7", gap, it.settle + 1);
                    if (it.last) begin
                        check(seq_done && !frm_valid, "R8", seq_done, 1);
                        @(negedge clk);
                        check(!seq_done, "R8", seq_done, 0);
                    end else begin
                        check(frm_valid && !seq_done, "R7", frm_valid, 1);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready == 1, "R10", req_ready, 1);
        check(frm_valid == 0, "R10", frm_valid, 0);
        check(seq_done == 0, "R10", seq_done, 0);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1 && !frm_valid, "R10", req_ready, 1);

        send(8'h28, 0, 0, 3, 0, "R4");
        send(8'h41, 1, 0, 0, 0, "R3");
        send(8'h3F, 0, 1, 2, 0, "R5");
        send(8'hA5, 1, 0, 7, 1, "R9");
        send(8'hFF, 1, 0, 20, 0, "R4");
        send(8'h00, 0, 0, 1, 0, "R3");
        send(8'hC6, 1, 1, 0, 1, "R5");

        @(negedge clk);
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (10) @(negedge clk);
        // R9: nothing issued once idle
        check(!frm_valid && exp_q.size() == 0, "R9", frm_valid, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule